// File: doc/BRIEF.md
# Configurable Phase-Frequency Detector

This block compares two edge streams, a reference stream and a divided oscillator (feedback) stream, and reports which one arrives first. Both inputs are asynchronous to the fast system clock. Each passes through a two-flop synchronizer and a rising-edge detector. A rising reference edge sets an UP flag, and a rising feedback edge sets a DN flag. Once both flags are set they stay set together for exactly two clock cycles and are then cleared together. Because that overlap always has a minimum width, the response near zero phase error has no dead zone.

Two output styles are derived from the flags. The first is a single-ended three-state output, modelled as a drive value plus an output-enable. It drives high when only DN is set, drives low when only UP is set, and is released (high impedance) otherwise. The second is a pair of active-low pulse outputs, one following each flag. An 8-bit control word can enable, disable or invert the single-ended output. It can also enable, disable or swap the pulse pair. Both inputs may toggle at no more than a quarter of the system-clock rate.

Top module: `phase_freq_comparator`

## Requirements
- R1: A rising edge on `ref_in` or `fb_in` first becomes visible at the outputs after the third rising clock edge that follows the input change. This latency comes from two synchronizer flops plus the flag register. Each detected edge is a one-cycle event.
- R2: When only UP is set (the feedback stream lags or is slower), with `ctrl[0]`=1 and `ctrl[1]`=0, `se_oe` is 1 and `se_drive` is 0.
- R3: When only DN is set (the feedback stream leads or is faster), with `ctrl[0]`=1 and `ctrl[1]`=0, `se_oe` is 1 and `se_drive` is 1.
- R4: Once both flags are set, they stay set for exactly 2 clock cycles and are then both cleared. During this time `se_oe` is 0.
- R5: With the polarity bit `ctrl[7]`=0 and `ctrl[2]`=1, `phi_v_n` is low exactly while DN is set, and `phi_r_n` is low exactly while UP is set.
- R6: With `ctrl[7]`=1, the two pulse outputs exchange roles: `phi_r_n` follows DN and `phi_v_n` follows UP.
- R7: Coincident input edges make `phi_r_n` and `phi_v_n` pulse low together for the same 2 cycles, then both return high.
- R8: With `ctrl[1]`=1, the drive value is inverted whenever `se_oe` is 1: UP alone drives 1 and DN alone drives 0.
- R9: With `ctrl[0]`=0, `se_oe` stays 0 whatever the flags are.
- R10: With `ctrl[2]`=0, `phi_r_n` and `phi_v_n` are both held high, and the hold takes effect in the same cycle that the bit changes.
- R11: A synchronous active-high `rst` clears both flags. While `rst` is high and after it is released, `se_oe` is 0 and both pulse outputs are high until a new edge is detected.
- R12: When one flag is already set and the other input's edge arrives later, the single-ended output stays active until the second flag is set. The overlap of R4 then follows and ends with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference edge stream, asynchronous |
| fb_in | input | 1 | Divided oscillator edge stream, asynchronous |
| ctrl | input | 8 | Control word: bit 0 single-ended enable, bit 1 single-ended invert, bit 2 pulse-pair enable, bit 7 polarity (swap) |
| se_drive | output | 1 | Single-ended drive value, meaningful while se_oe is 1 (held at 0 otherwise) |
| se_oe | output | 1 | Single-ended output-enable; 0 means high impedance |
| phi_r_n | output | 1 | Active-low pulse output, reference side |
| phi_v_n | output | 1 | Active-low pulse output, feedback side |

## Verification
The hardest case to reach is a late second edge that lands while the first flag has been set for several cycles. The window during which the output is driven must be measured exactly before the two-cycle overlap starts. The bench reaches this case by placing the two input edges a chosen number of clock cycles apart, in both orders. It records every output on each cycle and compares the record against latencies derived from the synchronizer depth.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int CTRL_W      = 8;
  localparam int BIT_SE_EN   = 0;
  localparam int BIT_SE_INV  = 1;
  localparam int BIT_DE_EN   = 2;
  localparam int BIT_POL     = 7;

  typedef struct packed {
    logic se_en;
    logic se_inv;
    logic de_en;
    logic swap;
  } pfd_cfg_t;

  function automatic pfd_cfg_t decode_ctrl(input logic [CTRL_W-1:0] word);
    pfd_cfg_t c;
    c.se_en  = word[BIT_SE_EN];
    c.se_inv = word[BIT_SE_INV];
    c.de_en  = word[BIT_DE_EN];
    c.swap   = word[BIT_POL];
    return c;
  endfunction

  // single-ended output is driven only when exactly one flag is set
  function automatic logic se_active(input logic up, input logic dn, input logic en);
    return en & (up ^ dn);
  endfunction

  // feedback leading (DN alone) drives high, lagging drives low; invert flips
  function automatic logic se_level(input logic up, input logic dn, input logic inv);
    return (dn & ~up) ^ inv;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

  // R1: an edge event never lasts longer than one cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/pfd_flags.sv
module pfd_flags #(
  parameter int MIN_OVERLAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up_q,
  output logic dn_q,
  output logic clear_evt
);

  localparam int CNT_W = $clog2(MIN_OVERLAP + 1);

  logic [CNT_W-1:0] ovl_cnt;
  logic             both_set;

  assign both_set  = up_q & dn_q;
  assign clear_evt = both_set & (ovl_cnt == CNT_W'(MIN_OVERLAP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      ovl_cnt <= '0;
    end else begin
      up_q <= ref_rise | (up_q & ~clear_evt);
      dn_q <= fb_rise  | (dn_q & ~clear_evt);
      if (both_set && !clear_evt) ovl_cnt <= ovl_cnt + CNT_W'(1);
      else                        ovl_cnt <= '0;
    end
  end

  // R4: after the overlap window both flags drop unless a fresh edge arrives
  a_r4_clear_after_overlap: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> (up_q == $past(ref_rise)) && (dn_q == $past(fb_rise)));

  // R4: the overlap counter never passes the minimum width
  a_r4_overlap_bounded: assert property (@(posedge clk) disable iff (rst)
    both_set |-> (ovl_cnt < CNT_W'(MIN_OVERLAP)));

endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_pkg::*;
(
  input  logic     up,
  input  logic     dn,
  input  pfd_cfg_t cfg,
  output logic     se_drive,
  output logic     se_oe,
  output logic     phi_r_n,
  output logic     phi_v_n
);

  logic r_side_n, v_side_n;

  always_comb begin
    se_oe    = se_active(up, dn, cfg.se_en);
    se_drive = se_oe ? se_level(up, dn, cfg.se_inv) : 1'b0;
  end

  always_comb begin
    if (cfg.swap) begin
      r_side_n = ~dn;
      v_side_n = ~up;
    end else begin
      r_side_n = ~up;
      v_side_n = ~dn;
    end
    phi_r_n = cfg.de_en ? r_side_n : 1'b1;
    phi_v_n = cfg.de_en ? v_side_n : 1'b1;
  end

endmodule

// File: rtl/phase_freq_comparator.sv
module phase_freq_comparator
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_OVERLAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              fb_in,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              se_drive,
  output logic              se_oe,
  output logic              phi_r_n,
  output logic              phi_v_n
);

  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise_evt;
  logic            up_q, dn_q, clear_evt;
  pfd_cfg_t        cfg;

  assign raw_in = {fb_in, ref_in};
  assign cfg    = decode_ctrl(ctrl);

  genvar i;
  generate
    for (i = 0; i < N_IN; i++) begin : g_sync
      pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_in[i]),
        .rise     (rise_evt[i])
      );
    end
  endgenerate

  pfd_flags #(.MIN_OVERLAP(MIN_OVERLAP)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .ref_rise  (rise_evt[0]),
    .fb_rise   (rise_evt[1]),
    .up_q      (up_q),
    .dn_q      (dn_q),
    .clear_evt (clear_evt)
  );

  pfd_out_stage u_out (
    .up       (up_q),
    .dn       (dn_q),
    .cfg      (cfg),
    .se_drive (se_drive),
    .se_oe    (se_oe),
    .phi_r_n  (phi_r_n),
    .phi_v_n  (phi_v_n)
  );

  // R2/R3/R4: output driven only while exactly one flag is held
  a_r4_hiz_on_overlap: assert property (@(posedge clk) disable iff (rst)
    (up_q && dn_q) |-> !se_oe);

  // R9: disabled single-ended output stays released
  a_r9_se_disabled: assert property (@(posedge clk) disable iff (rst)
    !ctrl[BIT_SE_EN] |-> !se_oe);

  // R10: disabled pulse pair rests high
  a_r10_de_disabled: assert property (@(posedge clk) disable iff (rst)
    !ctrl[BIT_DE_EN] |-> (phi_r_n && phi_v_n));

  // R7: both flags give a coincident low on both pulse outputs
  a_r7_lock_both_low: assert property (@(posedge clk) disable iff (rst)
    (up_q && dn_q && ctrl[BIT_DE_EN]) |-> (!phi_r_n && !phi_v_n));

  // R5/R6: at most one pulse output low when only one flag is held
  a_r5_single_side: assert property (@(posedge clk) disable iff (rst)
    (up_q ^ dn_q) |-> (phi_r_n || phi_v_n));

endmodule

// File: tb/test_phase_freq_comparator.sv
`timescale 1ns/1ps
module test_phase_freq_comparator;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic [7:0] ctrl = 8'h05;
  logic       se_drive, se_oe, phi_r_n, phi_v_n;

  int n_checks = 0;
  int n_fail   = 0;

  logic [3:0] rec [0:15];   // {se_oe, se_drive, phi_r_n, phi_v_n}

  always #10 clk = ~clk;    // 50 MHz

  phase_freq_comparator i_phase_freq_comparator (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .ctrl(ctrl),
    .se_drive(se_drive), .se_oe(se_oe), .phi_r_n(phi_r_n), .phi_v_n(phi_v_n)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (oe,drv,phi_r_n,phi_v_n)", req, act, exp);
    end
  endtask

  function automatic logic [3:0] now_out();
    return {se_oe, se_drive, phi_r_n, phi_v_n};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // inputs high for two cycles starting at the given slot; -1 means never
  task automatic run(input int ref_at, input int fb_at, input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      rec[t] = now_out();
      ref_in = (ref_at >= 0) && (t >= ref_at) && (t < ref_at + 2);
      fb_in  = (fb_at  >= 0) && (t >= fb_at)  && (t < fb_at  + 2);
    end
    ref_in = 1'b0; fb_in = 1'b0;
  endtask

  task automatic t_reset();
    ctrl = 8'h05;
    do_reset();
    @(negedge clk);
    chk("R11 idle after reset", now_out(), 4'b0011);
    run(0, -1, 5);
    chk("R11 flag set before reset", rec[4], 4'b1001);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset clears flags", now_out(), 4'b0011);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 stays idle after release", now_out(), 4'b0011);
  endtask

  task automatic t_ref_only();
    ctrl = 8'h05; do_reset();
    run(0, -1, 8);
    chk("R1 no output before third edge", rec[2], 4'b0011);
    chk("R1 R2 R5 ref lead visible", rec[3], 4'b1001);
    chk("R2 held while fb absent", rec[7], 4'b1001);
  endtask

  task automatic t_fb_only();
    ctrl = 8'h05; do_reset();
    run(-1, 0, 6);
    chk("R1 fb latency", rec[2], 4'b0011);
    chk("R3 R5 fb lead", rec[3], 4'b1110);
  endtask

  task automatic t_lock();
    ctrl = 8'h05; do_reset();
    run(0, 0, 8);
    chk("R4 R7 overlap cycle 1", rec[3], 4'b0000);
    chk("R4 R7 overlap cycle 2", rec[4], 4'b0000);
    chk("R4 R7 cleared after 2", rec[5], 4'b0011);
  endtask

  task automatic t_late_fb();
    ctrl = 8'h05; do_reset();
    run(0, 3, 10);
    chk("R12 up only first", rec[3], 4'b1001);
    chk("R12 up only still", rec[5], 4'b1001);
    chk("R12 overlap starts", rec[6], 4'b0000);
    chk("R12 overlap second", rec[7], 4'b0000);
    chk("R12 clean after overlap", rec[8], 4'b0011);
  endtask

  task automatic t_late_ref();
    ctrl = 8'h05; do_reset();
    run(3, 0, 10);
    chk("R12 dn only first", rec[3], 4'b1110);
    chk("R12 dn only last", rec[5], 4'b1110);
    chk("R12 overlap after dn", rec[6], 4'b0000);
    chk("R12 clean after dn overlap", rec[8], 4'b0011);
  endtask

  task automatic t_polarity();
    ctrl = 8'h85; do_reset();
    run(-1, 0, 5);
    chk("R6 swapped fb lead", rec[3], 4'b1101);
    do_reset();
    run(0, -1, 5);
    chk("R6 swapped ref lead", rec[3], 4'b1010);
  endtask

  task automatic t_invert();
    ctrl = 8'h07; do_reset();
    run(0, -1, 5);
    chk("R8 inverted up", rec[3], 4'b1101);
    do_reset();
    run(-1, 0, 5);
    chk("R8 inverted dn", rec[3], 4'b1010);
  endtask

  task automatic t_se_off();
    ctrl = 8'h04; do_reset();
    run(0, -1, 5);
    chk("R9 se disabled", rec[3], 4'b0001);
  endtask

  task automatic t_de_off();
    ctrl = 8'h01; do_reset();
    run(-1, 0, 5);
    chk("R10 pair disabled", rec[3], 4'b1111);
    ctrl = 8'h05;
    #1;
    chk("R10 pair re-enabled same cycle", now_out(), 4'b1110);
    ctrl = 8'h01;
    #1;
    chk("R10 pair disabled same cycle", now_out(), 4'b1111);
  endtask

  initial begin
    #(20 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ref_only();
    t_fb_only();
    t_lock();
    t_late_fb();
    t_late_ref();
    t_polarity();
    t_invert();
    t_se_off();
    t_de_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule